// File: doc/BRIEF.md
# I2C Bus Pacing and Stuck-Clock Watchdog

This block sits beside a bit-level I2C serial interface and drives it with a single 10-bit counter that has two jobs. The low three bits of the counter set the pace for a master. Each time they wrap, the block emits a one-cycle strobe. The interface uses these strobes as the earliest moments at which it may end an SCL high or low phase, a start setup, a stop setup or the bus-free gap. Because of this, a fast software response cannot shorten any of these intervals below its floor.

The full counter is a watchdog. It runs only while a frame is in progress, meaning the last start is more recent than the last stop or reset. Any change of level on SCL restarts it. If it reaches its all-ones value and the run-enable bit is set, the block pulses a reset into the interface, which makes the interface release SCL. It also sets a sticky timeout interrupt flag, provided that interrupt is enabled.

The counter advances once per machine cycle, marked by a clock-enable input. A 2-bit prescale code picks one of four reload values. The reload value sets both the length of the first pacing interval and the exact timeout length, which lets the timing suit different oscillator frequencies.

Top module: `i2c_pace_watchdog`

## Requirements
- R1: The counter advances only in clock cycles where `tickEn` is high. While `tickEn` is low, the counter is frozen and neither `minTimeMet` nor `ifaceReset` is asserted.
- R2: When the counter reloads, it takes the value 3 - s, where s is the value of `prescaleSel` (0 to 3). `minTimeMet` is a one-cycle pulse each time the low three counter bits wrap from 7 to 0. The first pulse therefore comes 5 + s ticks after the frame start, and later pulses come every 8 ticks.
- R3: With `runEn` high and SCL steady, `ifaceReset` pulses for exactly one clock cycle. The pulse comes 1020 + s ticks after the frame start, on the tick that would bring the counter to all ones (1023).
- R4: Any change of level on `sclSync` reloads the counter. The edge is registered first, so with `tickEn` held high the next timeout comes 1021 + s clock cycles after the change.
- R5: While `frameActive` is low, the counter is held at its reload value, and neither `minTimeMet` nor `ifaceReset` is asserted.
- R6: While `runEn` is low, `ifaceReset` never pulses and `timeoutIrq` is never set. The counter still wraps through all ones, and pacing continues with a period of 8 ticks.
- R7: `timeoutIrq` is set in the same cycle as `ifaceReset`, but only if `irqEnable` was high at the timeout. It stays set until `irqClear` is seen and drops in the following cycle. If a set and a clear coincide, the set wins.
- R8: A timeout reloads the counter. If the frame is still active and SCL stays steady, the next timeout comes another 1020 + s ticks later.
- R9: While reset is asserted and right after it is released, `minTimeMet`, `ifaceReset` and `timeoutIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Machine-cycle enable; the counter advances only when this is high |
| runEn | input | 1 | Enables the timeout reset and the timeout interrupt |
| prescaleSel | input | 2 | Reload select s; reload value is 3 - s |
| sclSync | input | 1 | SCL level, already synchronized to clk |
| frameActive | input | 1 | High between a start and the following stop or reset |
| irqEnable | input | 1 | Lets a timeout set the interrupt flag |
| irqClear | input | 1 | Clears the timeout interrupt flag |
| minTimeMet | output | 1 | One-cycle strobe when a minimum bus interval has elapsed |
| ifaceReset | output | 1 | One-cycle reset to the I2C interface on timeout |
| timeoutIrq | output | 1 | Sticky timeout interrupt flag |

## Verification
The bound checker watches several rules on every cycle. The interface reset is always a single cycle wide. It fires only when the run bit, the frame status and the tick enable were all high on the previous cycle, and it never coincides with a pacing strobe. The interrupt flag rises only together with a reset while interrupts are enabled, and it holds until a clear arrives. The exact tick counts cannot be shown by a per-cycle property and are left to the bench scenarios. These counts are the first-strobe offset and the timeout length for each prescale code, the extra cycle after an SCL change, the continued pacing with the run bit off and the re-arm after a timeout.

// File: rtl/i2c_pace_pkg.sv
package i2c_pace_pkg;

  // Commands from control to the counter datapath
  typedef struct packed {
    logic reload;   // load the prescale-derived start value
    logic advance;  // count up by one
  } cntCmd_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic sclEdge;    // SCL level differs from last sampled level
    logic paceWrap;   // low pacing bits are at their top value
    logic nearCarry;  // full counter is one below all ones
  } cntStat_t;

endpackage

// File: rtl/i2c_pace_datapath.sv
module i2c_pace_datapath
  import i2c_pace_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PACE_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [SEL_W-1:0] prescaleSel,
  input  logic             sclSync,
  output cntStat_t         stat
);

  localparam int PACE_TOP_I = (1 << PACE_W) - 1;
  localparam int HALF_I     = 1 << (PACE_W - 1);
  localparam int BASE_I     = PACE_TOP_I - HALF_I;
  localparam logic [CNT_W-1:0]  CNT_NEAR = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [PACE_W-1:0] PACE_TOP = {PACE_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] preloadVal;
  logic             sclPrev;

  // Reload value: base minus the prescale code
  always_comb begin
    preloadVal = CNT_W'(BASE_I) - CNT_W'(prescaleSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.reload) begin
      cnt <= preloadVal;
    end else if (cmd.advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stat.sclEdge   = sclSync ^ sclPrev;
    stat.paceWrap  = (cnt[PACE_W-1:0] == PACE_TOP);
    stat.nearCarry = (cnt == CNT_NEAR);
  end

endmodule

// File: rtl/i2c_pace_control.sv
module i2c_pace_control
  import i2c_pace_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     runEn,
  input  logic     frameActive,
  input  logic     irqEnable,
  input  logic     irqClear,
  input  cntStat_t stat,
  output cntCmd_t  cmd,
  output logic     minTimeMet,
  output logic     ifaceReset,
  output logic     timeoutIrq
);

  logic advanceNow;
  logic timeoutHit;
  logic paceHit;

  always_comb begin
    // An SCL edge restarts the count instead of advancing it
    advanceNow  = tickEn & frameActive & ~stat.sclEdge;
    timeoutHit  = advanceNow & runEn & stat.nearCarry;
    paceHit     = advanceNow & stat.paceWrap;
    cmd.advance = advanceNow;
    cmd.reload  = ~frameActive | stat.sclEdge | timeoutHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minTimeMet <= 1'b0;
      ifaceReset <= 1'b0;
    end else begin
      minTimeMet <= paceHit;
      ifaceReset <= timeoutHit;
    end
  end

  // Sticky flag; a new timeout wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutIrq <= 1'b0;
    end else if (timeoutHit && irqEnable) begin
      timeoutIrq <= 1'b1;
    end else if (irqClear) begin
      timeoutIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_pace_watchdog.sv
module i2c_pace_watchdog #(
  parameter int CNT_W  = 10,
  parameter int PACE_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             runEn,
  input  logic [SEL_W-1:0] prescaleSel,
  input  logic             sclSync,
  input  logic             frameActive,
  input  logic             irqEnable,
  input  logic             irqClear,
  output logic             minTimeMet,
  output logic             ifaceReset,
  output logic             timeoutIrq
);

  i2c_pace_pkg::cntCmd_t  cmd;
  i2c_pace_pkg::cntStat_t stat;

  i2c_pace_datapath #(
    .CNT_W (CNT_W),
    .PACE_W(PACE_W),
    .SEL_W (SEL_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .prescaleSel(prescaleSel),
    .sclSync    (sclSync),
    .stat       (stat)
  );

  i2c_pace_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .runEn      (runEn),
    .frameActive(frameActive),
    .irqEnable  (irqEnable),
    .irqClear   (irqClear),
    .stat       (stat),
    .cmd        (cmd),
    .minTimeMet (minTimeMet),
    .ifaceReset (ifaceReset),
    .timeoutIrq (timeoutIrq)
  );

endmodule

// File: rtl/i2c_pace_watchdog_chk.sv
module i2c_pace_watchdog_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             runEn,
  input logic [SEL_W-1:0] prescaleSel,
  input logic             sclSync,
  input logic             frameActive,
  input logic             irqEnable,
  input logic             irqClear,
  input logic             minTimeMet,
  input logic             ifaceReset,
  input logic             timeoutIrq
);

  // R3
  reset_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifaceReset |=> !ifaceReset);

  // R6
  reset_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifaceReset |-> $past(runEn));

  // R1
  reset_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifaceReset |-> ($past(tickEn) && $past(frameActive)));

  // R5
  pace_needs_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    minTimeMet |-> ($past(tickEn) && $past(frameActive)));

  // R2
  pace_not_at_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifaceReset |-> !minTimeMet);

  // R7
  irq_rise_with_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutIrq) |-> (ifaceReset && $past(irqEnable)));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timeoutIrq) && !$past(irqClear)) |-> timeoutIrq);

endmodule

bind i2c_pace_watchdog i2c_pace_watchdog_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/i2c_pace_watchdog_tb.sv
module i2c_pace_watchdog_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       runEn;
  logic [1:0] prescaleSel;
  logic       sclSync;
  logic       frameActive;
  logic       irqEnable;
  logic       irqClear;
  logic       minTimeMet;
  logic       ifaceReset;
  logic       timeoutIrq;

  int checks = 0;
  int fails  = 0;

  // prescale code, first pacing strobe tick, timeout tick
  localparam int VEC [4][3] = '{
    '{0, 5, 1020},
    '{1, 6, 1021},
    '{2, 7, 1022},
    '{3, 8, 1023}
  };

  always #10 clk = ~clk;

  i2c_pace_watchdog u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .runEn      (runEn),
    .prescaleSel(prescaleSel),
    .sclSync    (sclSync),
    .frameActive(frameActive),
    .irqEnable  (irqEnable),
    .irqClear   (irqClear),
    .minTimeMet (minTimeMet),
    .ifaceReset (ifaceReset),
    .timeoutIrq (timeoutIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Count negedges until the chosen output is high; -1 if never
  task automatic countUntil(input bit wantReset, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if ((wantReset ? ifaceReset : minTimeMet) == 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic countPulses(input int cycles, output int nPace, output int nRst);
    nPace = 0;
    nRst  = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (minTimeMet) nPace++;
      if (ifaceReset) nRst++;
    end
  endtask

  // Select the prescale while idle, then raise frameActive at a negedge
  task automatic startFrame(input int sel);
    @(negedge clk);
    frameActive = 1'b0;
    prescaleSel = 2'(sel);
    @(negedge clk);
    frameActive = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int n;
    int np;
    int nr;
    rstN = 1'b0; tickEn = 1'b1; runEn = 1'b1; prescaleSel = 2'd0;
    sclSync = 1'b1; frameActive = 1'b0; irqEnable = 1'b1; irqClear = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset minTimeMet", int'(minTimeMet), 0);
    check("R9 reset ifaceReset", int'(ifaceReset), 0);
    check("R9 reset timeoutIrq", int'(timeoutIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release outputs", int'({minTimeMet, ifaceReset, timeoutIrq}), 0);

    // Vector table: pacing, timeout, irq, re-arm for every prescale code
    for (int v = 0; v < 4; v++) begin
      startFrame(VEC[v][0]);
      countUntil(1'b0, 20, n);
      check($sformatf("R2 first pace s=%0d", VEC[v][0]), n, VEC[v][1]);
      countUntil(1'b0, 20, n);
      check($sformatf("R2 pace period s=%0d", VEC[v][0]), n, 8);
      countUntil(1'b1, 1100, n);
      check($sformatf("R3 timeout s=%0d", VEC[v][0]), n, VEC[v][2] - VEC[v][1] - 8);
      check($sformatf("R7 irq set s=%0d", VEC[v][0]), int'(timeoutIrq), 1);
      @(negedge clk);
      check($sformatf("R3 reset width s=%0d", VEC[v][0]), int'(ifaceReset), 0);
      check($sformatf("R7 irq sticky s=%0d", VEC[v][0]), int'(timeoutIrq), 1);
      countUntil(1'b1, 1100, n);
      check($sformatf("R8 second timeout s=%0d", VEC[v][0]), n, VEC[v][2] - 1);
      irqClear = 1'b1;
      @(negedge clk);
      irqClear = 1'b0;
      check($sformatf("R7 irq cleared s=%0d", VEC[v][0]), int'(timeoutIrq), 0);
      frameActive = 1'b0;
    end

    // R4: SCL change restarts the watchdog
    startFrame(0);
    countPulses(300, np, nr);
    check("R4 no reset before scl change", nr, 0);
    sclSync = 1'b0;
    countUntil(1'b1, 1100, n);
    check("R4 timeout after scl change", n, 1021);
    frameActive = 1'b0;
    sclSync = 1'b1;
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;

    // R5: no frame, no strobes
    countPulses(60, np, nr);
    check("R5 idle pace count", np, 0);
    check("R5 idle reset count", nr, 0);

    // R1: frozen while tickEn is low, then resumes from the reload value
    tickEn = 1'b0;
    startFrame(1);
    countPulses(40, np, nr);
    check("R1 frozen pace count", np, 0);
    tickEn = 1'b1;
    countUntil(1'b0, 20, n);
    check("R1 pace after tick resumes", n, 6);
    frameActive = 1'b0;

    // R6: run disabled, pacing continues through the wrap
    runEn = 1'b0;
    startFrame(2);
    countUntil(1'b0, 20, n);
    check("R6 first pace with run off", n, 7);
    countPulses(1100, np, nr);
    check("R6 no reset with run off", nr, 0);
    check("R6 pace count across wrap", np, 137);
    check("R6 irq stays low", int'(timeoutIrq), 0);
    frameActive = 1'b0;
    runEn = 1'b1;

    // R7: interrupt disabled, reset still happens
    irqEnable = 1'b0;
    startFrame(3);
    countUntil(1'b1, 1100, n);
    check("R7 timeout with irq off", n, 1023);
    check("R7 irq masked", int'(timeoutIrq), 0);
    frameActive = 1'b0;
    irqEnable = 1'b1;

    @(negedge clk);
    summary();
  end

endmodule